// File: doc/BRIEF.md
# Pipelined Fractional Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal-processing datapath. It takes two 24-bit operands and treats them as fractions. Each operand is read as signed two's-complement or as unsigned, chosen per operation and per operand. It then loads the doubled product into one of two 56-bit accumulators, or adds it to or subtracts it from that accumulator. Each accumulator is laid out as an 8-bit extension over a 24-bit high word over a 24-bit low word. An optional convergent rounding step folds the low word into the high word.

Operations enter through a single-cycle issue strobe and take two clocks. The product is registered in the first stage. The accumulator is read, updated and written in the second. Because the accumulator is read in the stage that writes it, an operation issued right behind another one to the same accumulator sees the earlier result, and the unit never stalls. A combinational read port returns either accumulator as a 24-bit operand. When the extension holds significant bits, that value is clamped to full scale.

Top module: `frac_mac`

## Requirements
- R1: While rst_ni is low, both accumulators are zero, done_o is 0, rd_data_o is 0 and rd_limit_o is 0.
- R2: Each operand is read as signed two's-complement when its sign flag is 1 and as unsigned when the flag is 0. The flags are independent. The product term is 2·a·b, sign-extended to 56 bits.
- R3: op_i is decoded as follows. 2'b00 and 2'b11 load the product term. 2'b01 adds it to the accumulator. 2'b10 subtracts it from the accumulator. All results wrap modulo 2^56.
- R4: dst_i = 0 writes accumulator A and dst_i = 1 writes accumulator B. The other accumulator is left unchanged.
- R5: An operation sampled with issue_i high at clock edge k updates its accumulator at edge k+1. done_o is high for exactly the cycle after edge k+1. done_o is low in every other cycle.
- R6: Operations may be issued on every clock. An operation sees the result of the operation issued one clock earlier to the same accumulator, with no stall.
- R7: With rnd_i = 1, the result has 2^23 added. Bit 24 is then cleared if the low 24 bits of the unrounded result were exactly 0x800000. Finally, bits 23:0 are cleared. With rnd_i = 0, all 56 bits are kept.
- R8: rd_sel_i = 0 selects A and rd_sel_i = 1 selects B. When bits 55:47 of the selected accumulator are all equal, rd_data_o is bits 47:24 and rd_limit_o is 0. Bits 23:0 do not affect the read-out.
- R9: When bits 55:47 are not all equal, rd_limit_o is 1. rd_data_o is then 0x7FFFFF if bit 55 is 0 and 0x800000 if bit 55 is 1.
- R10: A cycle with issue_i low changes neither accumulator, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Accept an operation this cycle |
| op_i | input | 2 | Operation code |
| dst_i | input | 1 | Target accumulator (0 = A, 1 = B) |
| rnd_i | input | 1 | Round the low word into the high word |
| sgn_a_i | input | 1 | Operand a is signed |
| sgn_b_i | input | 1 | Operand b is signed |
| opa_i | input | 24 | Operand a |
| opb_i | input | 24 | Operand b |
| rd_sel_i | input | 1 | Read-out accumulator select |
| rd_data_o | output | 24 | Limited 24-bit read-out |
| rd_limit_o | output | 1 | Read-out was clamped |
| done_o | output | 1 | An accumulator was written at the last edge |
| acc_a_o | output | 56 | Accumulator A |
| acc_b_o | output | 56 | Accumulator B |

## Verification
The bench goes after the exact-half low word, in two forms: one where the high word is even and one where it is odd. A design that rounds half up instead of to even gives a result one high-word LSB too large in the first form. The mixed-sign products are also targeted. Extending the unsigned operand by its top bit turns 0xFFFFFF into -1 and flips the product's sign. Back-to-back issues to the same accumulator are targeted as well: a design that reads the accumulator too early drops every other term. Full-scale unsigned squares push the extension past the sign, in both directions. A read-out that slices bits without the limit check returns a wrapped value where the clamped one is expected.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_SUB   = 2'b10,
    OP_LOAD2 = 2'b11
  } mac_op_e;
endpackage

// File: rtl/frac_mac_mult.sv
module frac_mac_mult
  import frac_mac_pkg::*;
#(
  parameter int OP_W  = 24,
  parameter int EXT_W = 8,
  parameter int SEL_W = 1,
  localparam int ACC_W = EXT_W + 2 * OP_W,
  localparam int PRD_W = 2 * OP_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  mac_op_e          op_i,
  input  logic [SEL_W-1:0] dst_i,
  input  logic             rnd_i,
  input  logic             sgn_a_i,
  input  logic             sgn_b_i,
  input  logic [OP_W-1:0]  opa_i,
  input  logic [OP_W-1:0]  opb_i,
  output logic             vld_o,
  output mac_op_e          op_o,
  output logic [SEL_W-1:0] dst_o,
  output logic             rnd_o,
  output logic [ACC_W-1:0] prod_o
);
  logic signed [OP_W:0]    ax, bx;
  logic signed [PRD_W-1:0] p;
  logic [ACC_W-1:0]        p_term;

  always_comb begin
    ax = {sgn_a_i & opa_i[OP_W-1], opa_i};
    bx = {sgn_b_i & opb_i[OP_W-1], opb_i};
    p  = ax * bx;
    // fractional alignment: one left shift
    p_term = {{(ACC_W-PRD_W){p[PRD_W-1]}}, p} << 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      op_o   <= OP_LOAD;
      dst_o  <= '0;
      rnd_o  <= 1'b0;
      prod_o <= '0;
    end else begin
      vld_o <= issue_i;
      if (issue_i) begin
        op_o   <= op_i;
        dst_o  <= dst_i;
        rnd_o  <= rnd_i;
        prod_o <= p_term;
      end
    end
  end
endmodule

// File: rtl/frac_mac_acc.sv
module frac_mac_acc
  import frac_mac_pkg::*;
#(
  parameter int OP_W  = 24,
  parameter int EXT_W = 8,
  parameter int N_ACC = 2,
  parameter int SEL_W = 1,
  localparam int ACC_W = EXT_W + 2 * OP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  mac_op_e          op_i,
  input  logic [SEL_W-1:0] dst_i,
  input  logic             rnd_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [ACC_W-1:0] acc_o [N_ACC],
  output logic             done_o
);
  localparam logic [ACC_W-1:0] HALF = {{(ACC_W-OP_W){1'b0}}, 1'b1, {(OP_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q [N_ACC];
  logic [ACC_W-1:0] cur, sum, rsum, res;
  logic             tie;

  assign cur = acc_q[dst_i];

  always_comb begin
    unique case (op_i)
      OP_ADD:  sum = cur + prod_i;
      OP_SUB:  sum = cur - prod_i;
      default: sum = prod_i;
    endcase
    tie  = (sum[OP_W-1:0] == HALF[OP_W-1:0]);
    rsum = sum + HALF;
    if (tie) rsum[OP_W] = 1'b0;  // round half to even
    rsum[OP_W-1:0] = '0;
    res = rnd_i ? rsum : sum;
  end

  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q[i] <= '0;
      else if (vld_i && dst_i == SEL_W'(i)) acc_q[i] <= res;
    end
    assign acc_o[i] = acc_q[i];

    AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!vld_i || dst_i != SEL_W'(i)) |=> $stable(acc_q[i]));  // R4 R10
    AST_LOAD_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && dst_i == SEL_W'(i) && !rnd_i && (op_i == OP_LOAD || op_i == OP_LOAD2))
      |=> acc_q[i] == $past(prod_i));  // R3
    AST_RND_LSP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && dst_i == SEL_W'(i) && rnd_i) |=> acc_q[i][OP_W-1:0] == '0);  // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= vld_i;
  end

  AST_DONE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> done_o);  // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !done_o);  // R5
endmodule

// File: rtl/frac_mac_limit.sv
module frac_mac_limit #(
  parameter int OP_W  = 24,
  parameter int EXT_W = 8,
  localparam int ACC_W = EXT_W + 2 * OP_W,
  localparam int TOP_W = EXT_W + 1
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [OP_W-1:0]  data_o,
  output logic             limit_o
);
  logic [TOP_W-1:0] top;

  always_comb begin
    top     = acc_i[ACC_W-1 -: TOP_W];
    limit_o = !((&top) || !(|top));
    if (!limit_o)           data_o = acc_i[2*OP_W-1 -: OP_W];
    else if (acc_i[ACC_W-1]) data_o = {1'b1, {(OP_W-1){1'b0}}};
    else                    data_o = {1'b0, {(OP_W-1){1'b1}}};
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int OP_W  = 24,
  parameter int EXT_W = 8,
  localparam int ACC_W = EXT_W + 2 * OP_W,
  localparam int N_ACC = 2,
  localparam int SEL_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [1:0]       op_i,
  input  logic             dst_i,
  input  logic             rnd_i,
  input  logic             sgn_a_i,
  input  logic             sgn_b_i,
  input  logic [OP_W-1:0]  opa_i,
  input  logic [OP_W-1:0]  opb_i,
  input  logic             rd_sel_i,
  output logic [OP_W-1:0]  rd_data_o,
  output logic             rd_limit_o,
  output logic             done_o,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o
);
  logic             s1_vld, s1_rnd;
  mac_op_e          s1_op;
  logic [SEL_W-1:0] s1_dst;
  logic [ACC_W-1:0] s1_prod;
  logic [ACC_W-1:0] acc [N_ACC];
  logic [ACC_W-1:0] rd_acc;

  frac_mac_mult #(.OP_W(OP_W), .EXT_W(EXT_W), .SEL_W(SEL_W)) u_mult (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue_i),
    .op_i    (mac_op_e'(op_i)),
    .dst_i   (dst_i),
    .rnd_i   (rnd_i),
    .sgn_a_i (sgn_a_i),
    .sgn_b_i (sgn_b_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .vld_o   (s1_vld),
    .op_o    (s1_op),
    .dst_o   (s1_dst),
    .rnd_o   (s1_rnd),
    .prod_o  (s1_prod)
  );

  frac_mac_acc #(.OP_W(OP_W), .EXT_W(EXT_W), .N_ACC(N_ACC), .SEL_W(SEL_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s1_vld),
    .op_i   (s1_op),
    .dst_i  (s1_dst),
    .rnd_i  (s1_rnd),
    .prod_i (s1_prod),
    .acc_o  (acc),
    .done_o (done_o)
  );

  assign acc_a_o = acc[0];
  assign acc_b_o = acc[1];
  assign rd_acc  = acc[rd_sel_i];

  frac_mac_limit #(.OP_W(OP_W), .EXT_W(EXT_W)) u_limit (
    .acc_i   (rd_acc),
    .data_o  (rd_data_o),
    .limit_o (rd_limit_o)
  );

  AST_SAT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_limit_o |-> (rd_data_o == {1'b0, {(OP_W-1){1'b1}}} ||
                    rd_data_o == {1'b1, {(OP_W-1){1'b0}}}));  // R9
  AST_SAT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_limit_o |-> rd_data_o[OP_W-1] == rd_acc[ACC_W-1]);  // R9
  AST_ISSUE_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> s1_vld);  // R6
endmodule

// File: tb/frac_mac_tb.sv
module frac_mac_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        dst = 1'b0, rnd = 1'b0, sa = 1'b0, sb = 1'b0, rsel = 1'b0;
  logic [23:0] opa = '0, opb = '0;
  logic [23:0] rd_data;
  logic        rd_limit, done;
  logic [55:0] acc_a, acc_b;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [55:0] ca = '0, cb = '0, pa = '0, pb = '0;
  logic        iss_d1 = 1'b0, iss_d2 = 1'b0, rsel_d1 = 1'b0;

  always #4 clk = ~clk;

  frac_mac dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op), .dst_i(dst),
    .rnd_i(rnd), .sgn_a_i(sa), .sgn_b_i(sb), .opa_i(opa), .opb_i(opb),
    .rd_sel_i(rsel), .rd_data_o(rd_data), .rd_limit_o(rd_limit),
    .done_o(done), .acc_a_o(acc_a), .acc_b_o(acc_b)
  );

  function automatic logic [55:0] f_prod(logic [23:0] a, logic [23:0] b, logic fa, logic fb);
    logic signed [55:0] x, y;
    x = fa ? {{32{a[23]}}, a} : {32'b0, a};
    y = fb ? {{32{b[23]}}, b} : {32'b0, b};
    return (x * y) << 1;
  endfunction

  function automatic logic [55:0] f_apply(logic [55:0] acc, logic [1:0] o, logic r, logic [55:0] p);
    logic [55:0] s, t;
    s = (o == 2'b01) ? acc + p : (o == 2'b10) ? acc - p : p;
    if (!r) return s;
    t = s + 56'h800000;
    if (s[23:0] == 24'h800000) t[24] = 1'b0;
    t[23:0] = '0;
    return t;
  endfunction

  function automatic logic [24:0] f_read(logic [55:0] acc);
    if (acc[55:47] == 9'h1FF || acc[55:47] == 9'h000) return {1'b0, acc[47:24]};
    return acc[55] ? {1'b1, 24'h800000} : {1'b1, 24'h7FFFFF};
  endfunction

  task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic i, input logic [1:0] o, input logic d, input logic fa,
                      input logic fb, input logic r, input logic [23:0] a, input logic [23:0] b,
                      input logic s);
    logic [24:0] er;
    @(negedge clk);
    chk("R3/R6 acc A", acc_a, pa);
    chk("R4/R6 acc B", acc_b, pb);
    chk("R5 done", {55'b0, done}, {55'b0, iss_d2});
    er = f_read(rsel_d1 ? pb : pa);
    chk("R8/R9 read", {31'b0, rd_limit, rd_data}, {31'b0, er});
    issue = i; op = o; dst = d; sa = fa; sb = fb; rnd = r; opa = a; opb = b; rsel = s;
    pa = ca; pb = cb;
    iss_d2 = iss_d1; iss_d1 = i; rsel_d1 = s;
    if (i) begin
      if (d) cb = f_apply(cb, o, r, f_prod(a, b, fa, fb));
      else   ca = f_apply(ca, o, r, f_prod(a, b, fa, fb));
    end
  endtask

  task automatic idle(input int n, input logic s);
    for (int k = 0; k < n; k++) step(1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 24'hFFFFFF, 24'hFFFFFF, s);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 acc A", acc_a, '0);
    chk("R1 acc B", acc_b, '0);
    chk("R1 done/read", {30'b0, done, rd_limit, rd_data}, '0);
    rst_n = 1'b1;

    // R2 sign modes
    step(1, 2'b00, 0, 1, 1, 0, 24'hFFFFFF, 24'hFFFFFF, 0);
    step(1, 2'b00, 1, 1, 0, 0, 24'hFFFFFF, 24'hFFFFFF, 0);
    idle(2, 0);
    chk("R2 signed x signed", acc_a, 56'h2);
    chk("R2 signed x unsigned", acc_b, 56'hFFFFFFFE000002);
    step(1, 2'b11, 0, 0, 1, 0, 24'hFFFFFF, 24'hFFFFFF, 0);
    idle(2, 0);
    chk("R2 unsigned x signed", acc_a, 56'hFFFFFFFE000002);
    chk("R4 B untouched", acc_b, 56'hFFFFFFFE000002);

    // R7 convergent rounding
    step(1, 2'b00, 0, 1, 1, 1, 24'h000800, 24'h000800, 0);
    idle(2, 0);
    chk("R7 half even", acc_a, 56'h0);
    step(1, 2'b00, 0, 1, 1, 0, 24'h001000, 24'h000800, 0);
    step(1, 2'b01, 0, 1, 1, 1, 24'h000800, 24'h000800, 0);
    idle(2, 0);
    chk("R7 half odd", acc_a, 56'h2000000);
    step(1, 2'b00, 0, 1, 1, 1, 24'h000800, 24'h000C00, 0);
    idle(2, 0);
    chk("R7 above half", acc_a, 56'h1000000);
    step(1, 2'b00, 0, 1, 1, 0, 24'h000800, 24'h000C00, 0);
    idle(2, 0);
    chk("R7 truncate keeps LSP", acc_a, 56'hC00000);
    chk("R8 LSP ignored", {32'b0, rd_data}, 56'h0);

    // R9 saturation both ways, R6 back-to-back on B
    step(1, 2'b00, 1, 0, 0, 0, 24'hFFFFFF, 24'hFFFFFF, 1);
    idle(2, 1);
    chk("R9 positive clamp", {31'b0, rd_limit, rd_data}, {31'b0, 1'b1, 24'h7FFFFF});
    step(1, 2'b10, 1, 0, 0, 0, 24'hFFFFFF, 24'hFFFFFF, 1);
    step(1, 2'b10, 1, 0, 0, 0, 24'hFFFFFF, 24'hFFFFFF, 1);
    idle(2, 1);
    chk("R9 negative clamp", {31'b0, rd_limit, rd_data}, {31'b0, 1'b1, 24'h800000});
    chk("R6 chained subtract", acc_b, 56'h0 - f_prod(24'hFFFFFF, 24'hFFFFFF, 0, 0));

    // R10 idle with busy inputs
    idle(4, 0);
    chk("R10 A held", acc_a, 56'hC00000);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] a, b;
      a = 24'($urandom);
      b = 24'($urandom);
      if ($urandom % 3 == 0) a = a >> ($urandom % 20);
      step(($urandom % 4) != 0, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), a, b, 1'($urandom));
    end
    idle(3, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule